// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block decides, on every system clock, whether an attached timer/counter advances. A three-bit select field picks one of eight sources: the timer held still, every clock, one clock in 8, 64, 256 or 1024, or one tick per falling or per rising transition of an external count pin. The result is a single-clock-wide count enable, `tick_o`. The counter that consumes it is not part of this block.

A free-running 10-bit prescaler counter supplies the division taps. A prescaler clear strobe zeroes it. The external pin is sampled through a two-flop synchronizer and then an edge detector. The pin is used whatever drives it, so software that toggles the pin as an output can still step the timer.

Top module: `tsel_clk_select`

## Requirements
- R1: While `rst_ni` is low, `tick_o` is 0. After release, the first clock edge applies the select field normally.
- R2: Select 3'b000 stops the timer. Every edge that samples this code leaves `tick_o` at 0.
- R3: Select 3'b001 sets `tick_o` to 1 after every edge that samples it. This holds even in a cycle with the clear strobe.
- R4: Selects 3'b010 and 3'b011 divide by 8 and by 64. After a clear, exactly 2048/N ticks occur in the next 2048 clocks.
- R5: Selects 3'b100 and 3'b101 divide by 256 and by 1024, with the same counting rule as R4.
- R6: For the divided codes 3'b010 to 3'b101, the edge that samples `psc_clr_i`=1 zeroes the prescaler and leaves `tick_o` at 0. The first tick follows the N-th edge after that clearing edge.
- R7: Select 3'b110 gives exactly one tick per falling transition of `ext_pin_i`. Rising transitions give none.
- R8: Select 3'b111 gives exactly one tick per rising transition of `ext_pin_i`. Falling transitions give none.
- R9: In either external mode a tick lasts one clock, and two ticks never fall on consecutive clocks.
- R10: A new select value takes effect at the next clock edge, not before it. Changing the select does not reset the prescaler's phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Count source select |
| psc_clr_i | input | 1 | Prescaler clear strobe |
| ext_pin_i | input | 1 | Raw external count pin |
| tick_o | output | 1 | One-clock count enable |

## Verification
The bench goes after the phase of the first divided tick after a clear. A design that did not suppress the tick on the clearing edge, or that cleared one cycle late, would move that tick by one clock or add an extra tick. A select change made in the middle of a prescale period must pick up the running count; a design that reset the prescaler there would place the 64-ratio tick at the wrong clock. The external modes are driven with full pulses, so a design with swapped polarity, a missing edge detector or a level-sensitive tick would give twice as many ticks, none, or long ticks. The bench also checks that a select write has no effect until the next edge, which catches a combinational path from select to tick.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  typedef enum logic [2:0] {
    SRC_OFF      = 3'b000,
    SRC_DIV1     = 3'b001,
    SRC_DIV8     = 3'b010,
    SRC_DIV64    = 3'b011,
    SRC_DIV256   = 3'b100,
    SRC_DIV1024  = 3'b101,
    SRC_EXT_FALL = 3'b110,
    SRC_EXT_RISE = 3'b111
  } src_sel_e;

  localparam int PSC_W    = 10;
  localparam int NUM_TAPS = 4;
  localparam int SYNC_LEN = 2;

  // log2 of the prescale ratio for each tap, lowest ratio first
  function automatic int tap_bits(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/tsel_prescaler.sv
module tsel_prescaler #(
  parameter int CNT_W    = tsel_pkg::PSC_W,
  parameter int NUM_TAPS = tsel_pkg::NUM_TAPS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  output logic [NUM_TAPS-1:0] tap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    localparam int B = tsel_pkg::tap_bits(g);
    assign tap_o[g] = &cnt_q[B-1:0];
  end
endmodule

// File: rtl/tsel_ext_edge.sv
module tsel_ext_edge #(
  parameter int SYNC_LEN = tsel_pkg::SYNC_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // SYNC_LEN synchronizer stages plus one history stage
  logic [SYNC_LEN:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_LEN-1:0], pin_i};
  end

  assign rise_o =  sh_q[SYNC_LEN-1] & ~sh_q[SYNC_LEN];
  assign fall_o = ~sh_q[SYNC_LEN-1] &  sh_q[SYNC_LEN];
endmodule

// File: rtl/tsel_clk_select.sv
module tsel_clk_select
  import tsel_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       psc_clr_i,
  input  logic       ext_pin_i,
  output logic       tick_o
);
  logic [NUM_TAPS-1:0] tap;
  logic                rise, fall;
  logic                tick_d, tick_q;
  src_sel_e            sel;

  tsel_prescaler #(.CNT_W(PSC_W), .NUM_TAPS(NUM_TAPS)) i_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (psc_clr_i),
    .tap_o  (tap)
  );

  tsel_ext_edge #(.SYNC_LEN(SYNC_LEN)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign sel = src_sel_e'(sel_i);

  always_comb begin
    unique case (sel)
      SRC_OFF:      tick_d = 1'b0;
      SRC_DIV1:     tick_d = 1'b1;
      SRC_DIV8:     tick_d = tap[0] & ~psc_clr_i;
      SRC_DIV64:    tick_d = tap[1] & ~psc_clr_i;
      SRC_DIV256:   tick_d = tap[2] & ~psc_clr_i;
      SRC_DIV1024:  tick_d = tap[3] & ~psc_clr_i;
      SRC_EXT_FALL: tick_d = fall;
      SRC_EXT_RISE: tick_d = rise;
      default:      tick_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= tick_d;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/tsel_checker.sv
module tsel_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] sel_i,
  input logic       psc_clr_i,
  input logic       tick_o
);
  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!tick_o);
    end
  end

  assert_stop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b000) |=> !tick_o);

  assert_div1_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b001) |=> tick_o);

  assert_clr_suppress_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psc_clr_i && sel_i >= 3'b010 && sel_i <= 3'b101) |=> !tick_o);

  assert_ext_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i[2:1] == 2'b11 && $past(sel_i) == sel_i) |=> !tick_o);
endmodule

bind tsel_clk_select tsel_checker i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .psc_clr_i (psc_clr_i),
  .tick_o    (tick_o)
);

// File: tb/test_tsel_clk_select.sv
`timescale 1ns/1ps
module test_tsel_clk_select;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] sel_i = 3'b000;
  logic       psc_clr_i = 1'b0;
  logic       ext_pin_i = 1'b0;
  logic       tick_o;

  int n_tests = 0;
  int n_fail  = 0;

  tsel_clk_select i_tsel_clk_select (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i),
    .psc_clr_i(psc_clr_i), .ext_pin_i(ext_pin_i), .tick_o(tick_o)
  );

  always #5 clk_i = ~clk_i;

  localparam int WIN = 2048;
  localparam int NV  = 6;
  // select, expected tick count in WIN clocks after clear, expected first tick edge
  localparam int V_SEL   [NV] = '{0, 1, 2, 3, 4, 5};
  localparam int V_CNT   [NV] = '{0, WIN, WIN/8, WIN/64, WIN/256, WIN/1024};
  localparam int V_FIRST [NV] = '{0, 1, 8, 64, 256, 1024};

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulses(input int n, inout int cnt);
    for (int p = 0; p < n; p++) begin
      ext_pin_i = 1'b1;
      for (int k = 0; k < 6; k++) begin step(); cnt += int'(tick_o); end
      ext_pin_i = 1'b0;
      for (int k = 0; k < 6; k++) begin step(); cnt += int'(tick_o); end
    end
  endtask

  initial begin
    #1_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cnt, first, back2back;
    logic prev;

    // R1: held in reset with the every-clock code selected
    sel_i = 3'b001;
    for (int k = 0; k < 4; k++) step();
    check("R1 reset quiet", int'(tick_o), 0);
    rst_ni = 1'b1;
    check("R1 no tick before first edge", int'(tick_o), 0);
    step();
    check("R1 first edge after release", int'(tick_o), 1);

    // Vector table: R2..R6
    for (int v = 0; v < NV; v++) begin
      sel_i = 3'(V_SEL[v]);
      psc_clr_i = 1'b1;
      step();
      psc_clr_i = 1'b0;
      check(v == 1 ? "R3 clear ignored" : "R6 clear-edge tick", int'(tick_o), v == 1 ? 1 : 0);
      cnt = 0;
      first = 0;
      for (int i = 1; i <= WIN; i++) begin
        step();
        if (tick_o) begin
          cnt++;
          if (first == 0) first = i;
        end
      end
      case (v)
        0:       check("R2 stopped count", cnt, V_CNT[v]);
        1:       check("R3 every clock count", cnt, V_CNT[v]);
        2, 3:    check("R4 divided count", cnt, V_CNT[v]);
        default: check("R5 divided count", cnt, V_CNT[v]);
      endcase
      check("R6 first tick edge", first, V_FIRST[v]);
    end

    // R10: switch 8 -> 64 mid period keeps prescaler phase
    sel_i = 3'b010;
    psc_clr_i = 1'b1;
    step();
    psc_clr_i = 1'b0;
    cnt = 0;
    first = 0;
    for (int i = 1; i <= 64; i++) begin
      if (i == 4) sel_i = 3'b011;
      step();
      if (tick_o) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
    check("R10 phase kept first tick", first, 64);
    check("R10 phase kept count", cnt, 1);

    // R10: select takes effect on the next edge only
    sel_i = 3'b001;
    step();
    step();
    sel_i = 3'b000;
    #1;
    check("R10 no effect before edge", int'(tick_o), 1);
    step();
    check("R10 stop after edge", int'(tick_o), 0);
    sel_i = 3'b001;
    #1;
    check("R10 still stopped before edge", int'(tick_o), 0);
    step();
    check("R10 run after edge", int'(tick_o), 1);

    // R8, R9: rising mode, full pulses
    sel_i = 3'b111;
    ext_pin_i = 1'b0;
    for (int k = 0; k < 5; k++) step();
    cnt = 0;
    pulses(5, cnt);
    check("R8 one tick per rise", cnt, 5);

    // R7: falling mode
    sel_i = 3'b110;
    for (int k = 0; k < 5; k++) step();
    cnt = 0;
    pulses(5, cnt);
    check("R7 one tick per fall", cnt, 5);

    // R7: a lone rise in falling mode is ignored
    cnt = 0;
    ext_pin_i = 1'b1;
    for (int k = 0; k < 8; k++) begin step(); cnt += int'(tick_o); end
    check("R7 rise ignored", cnt, 0);
    ext_pin_i = 1'b0;
    for (int k = 0; k < 8; k++) step();

    // R9: short pulses, ticks never adjacent
    sel_i = 3'b111;
    step();
    back2back = 0;
    cnt = 0;
    prev = 1'b0;
    for (int p = 0; p < 6; p++) begin
      ext_pin_i = 1'b1;
      step();
      if (tick_o && prev) back2back++;
      prev = tick_o; cnt += int'(tick_o);
      ext_pin_i = 1'b0;
      step();
      if (tick_o && prev) back2back++;
      prev = tick_o; cnt += int'(tick_o);
    end
    for (int k = 0; k < 5; k++) begin
      step();
      if (tick_o && prev) back2back++;
      prev = tick_o; cnt += int'(tick_o);
    end
    check("R9 no adjacent ticks", back2back, 0);
    check("R9 two-cycle pulses counted", cnt, 6);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule